// File: doc/BRIEF.md
# Wait Mode Clock Controller

This block sits between the CPU core and the clock tree of a small controller. When the core reports that it has executed a wait instruction, the block turns off the CPU clock enable and leaves the peripheral clock enable on. Timers, serial ports and the watchdog therefore keep running while the core is idle. The same entry event sends a one-cycle pulse that clears the core's interrupt mask, so that a peripheral interrupt can be taken once the core is running again.

The idle period ends in one of three ways: an interrupt line that is both requested and enabled, a break request from the debug logic, or reset. An interrupt wake restarts the CPU clock and pulses a stack-start strobe in the cycle after the interrupt was sampled. A break wake restarts the clock, gives no stacking strobe, and sets a sticky break-in-wait flag that software clears by writing zero to it. The watchdog run enable follows an active-low configuration disable bit and does not depend on the idle state.

Top module: `wait_clk_ctrl`

## Requirements
- R1: A `wait_strobe` sampled while `cpu_clk_en` is 1 and no wake source is present drives `cpu_clk_en` to 0 from the next cycle. It stays 0 until a wake occurs. `per_clk_en` is 1 in every cycle.
- R2: A `wait_strobe` or `stop_strobe` sampled while `cpu_clk_en` is 1 gives `imask_clr` = 1 for exactly the next cycle.
- R3: An interrupt line i counts only when `irq_req[i]` and `irq_en[i]` are both 1. If one such line is sampled while the CPU clock is off, then in the next cycle `cpu_clk_en` = 1 and `stack_go` = 1, and `stack_go` is high for that single cycle.
- R4: While the CPU clock is off, request lines whose enable bit is 0 change neither `cpu_clk_en` nor `stack_go`.
- R5: A `brk_req` sampled while the CPU clock is off makes `cpu_clk_en` = 1 and `brk_wait_flag` = 1 in the next cycle, and `stack_go` stays 0.
- R6: `wdog_run` equals the inverse of `wdog_off_cfg` both while the CPU clock is off and while it is on.
- R7: A `flag_wr` with `flag_wdata` = 0 clears `brk_wait_flag` in the next cycle. A write with 1 leaves it unchanged. A set and a clear in the same cycle leave the flag at 1.
- R8: If a wake source is present in the same cycle as `wait_strobe`, `cpu_clk_en` stays 1 in the next cycle. An interrupt still pulses `stack_go`, a break still sets the flag, and `imask_clr` still pulses.
- R9: If an enabled interrupt and `brk_req` are sampled together while waiting, the flag is set and `stack_go` stays 0.
- R10: While `rst_n` is 0, and also when the CPU clock was off before reset, the outputs are `cpu_clk_en` = 1, `brk_wait_flag` = 0, `imask_clr` = 0 and `stack_go` = 0.
- R11: Interrupts and `brk_req` that arrive while running with no strobe give neither `stack_go` nor a flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_strobe | input | 1 | Core has executed a wait instruction |
| stop_strobe | input | 1 | Core has executed a stop instruction (mask clear only) |
| irq_req | input | N_IRQ | Peripheral interrupt requests |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| brk_req | input | 1 | Break request from debug logic |
| wdog_off_cfg | input | 1 | Watchdog disable configuration bit |
| flag_wr | input | 1 | Write strobe for the break-in-wait flag |
| flag_wdata | input | 1 | Write data for the flag (0 clears) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| imask_clr | output | 1 | One-cycle interrupt mask clear |
| stack_go | output | 1 | One-cycle interrupt stacking start |
| brk_wait_flag | output | 1 | Break ended a wait |
| wdog_run | output | 1 | Watchdog enable |

## Verification
The bench builds the block with `N_IRQ` = 4, so it can sweep all 256 combinations of request and enable vectors. After each combination it computes the expected wake with a bitwise AND and an OR-reduction. Each combination that does not wake is then ended by a break, which also exercises setting and clearing the flag. Separate directed cases cover a wake in the same cycle as the strobe, break and interrupt together, the watchdog bit in both states, and reset while the CPU clock is off.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_IDLE = 1'b1
  } wmc_state_e;
endpackage

// File: rtl/wmc_wake_arb.sv
module wmc_wake_arb #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             brk_req,
  output logic             irq_wake,
  output logic             brk_wake
);
  logic [N_IRQ-1:0] line_hit;

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_line
    assign line_hit[gi] = irq_req[gi] & irq_en[gi];
  end

  // break outranks interrupts
  assign brk_wake = brk_req;
  assign irq_wake = (|line_hit) & ~brk_req;
endmodule

// File: rtl/wmc_seq.sv
module wmc_seq
  import wmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_strobe,
  input  logic stop_strobe,
  input  logic irq_wake,
  input  logic brk_wake,
  output logic cpu_run,
  output logic imask_clr,
  output logic stack_go,
  output logic brk_evt
);
  wmc_state_e state_q, state_d;
  logic       imask_q, imask_d;
  logic       stack_q, stack_d;

  always_comb begin
    state_d = state_q;
    imask_d = 1'b0;
    stack_d = 1'b0;
    brk_evt = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wait_strobe || stop_strobe) imask_d = 1'b1;
        if (wait_strobe) begin
          if (brk_wake)      brk_evt = 1'b1;
          else if (irq_wake) stack_d = 1'b1;
          else               state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (brk_wake) begin
          brk_evt = 1'b1;
          state_d = ST_RUN;
        end else if (irq_wake) begin
          stack_d = 1'b1;
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      imask_q <= 1'b0;
      stack_q <= 1'b0;
    end else begin
      state_q <= state_d;
      imask_q <= imask_d;
      stack_q <= stack_d;
    end
  end

  assign cpu_run   = (state_q == ST_RUN);
  assign imask_clr = imask_q;
  assign stack_go  = stack_q;
endmodule

// File: rtl/wmc_brk_flag.sv
module wmc_brk_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)                 flag_d = 1'b1;
    else if (wr_i && !wdata_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wait_clk_ctrl.sv
module wait_clk_ctrl #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_strobe,
  input  logic             stop_strobe,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             brk_req,
  input  logic             wdog_off_cfg,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             imask_clr,
  output logic             stack_go,
  output logic             brk_wait_flag,
  output logic             wdog_run
);
  logic irq_wake;
  logic brk_wake;
  logic brk_evt;

  wmc_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .brk_req  (brk_req),
    .irq_wake (irq_wake),
    .brk_wake (brk_wake)
  );

  wmc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_strobe (wait_strobe),
    .stop_strobe (stop_strobe),
    .irq_wake    (irq_wake),
    .brk_wake    (brk_wake),
    .cpu_run     (cpu_clk_en),
    .imask_clr   (imask_clr),
    .stack_go    (stack_go),
    .brk_evt     (brk_evt)
  );

  wmc_brk_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (brk_evt),
    .wr_i    (flag_wr),
    .wdata_i (flag_wdata),
    .flag_o  (brk_wait_flag)
  );

  // peripherals are never gated by this block
  assign per_clk_en = 1'b1;
  assign wdog_run   = ~wdog_off_cfg;
endmodule

// File: rtl/wait_clk_ctrl_chk.sv
module wait_clk_ctrl_chk #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wait_strobe,
  input logic             stop_strobe,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic             brk_req,
  input logic             wdog_off_cfg,
  input logic             flag_wr,
  input logic             flag_wdata,
  input logic             cpu_clk_en,
  input logic             imask_clr,
  input logic             stack_go,
  input logic             brk_wait_flag,
  input logic             wdog_run
);
  logic hit;
  assign hit = |(irq_req & irq_en);

  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && wait_strobe && !hit && !brk_req) |=> !cpu_clk_en); // R1
  AST_MASK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && (wait_strobe || stop_strobe)) |=> imask_clr); // R2
  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && hit && !brk_req) |=> (cpu_clk_en && stack_go)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !hit && !brk_req) |=> (!cpu_clk_en && !stack_go)); // R4
  AST_BRK_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && brk_req) |=> (cpu_clk_en && brk_wait_flag && !stack_go)); // R5
  AST_WDOG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !wdog_off_cfg) |-> wdog_run); // R6
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata && !(brk_req && (!cpu_clk_en || wait_strobe))) |=> !brk_wait_flag); // R7
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && wait_strobe && (hit || brk_req)) |=> cpu_clk_en); // R8
  AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !wait_strobe) |=> !stack_go); // R11
endmodule

bind wait_clk_ctrl wait_clk_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wait_strobe  (wait_strobe),
  .stop_strobe  (stop_strobe),
  .irq_req      (irq_req),
  .irq_en       (irq_en),
  .brk_req      (brk_req),
  .wdog_off_cfg (wdog_off_cfg),
  .flag_wr      (flag_wr),
  .flag_wdata   (flag_wdata),
  .cpu_clk_en   (cpu_clk_en),
  .imask_clr    (imask_clr),
  .stack_go     (stack_go),
  .brk_wait_flag(brk_wait_flag),
  .wdog_run     (wdog_run)
);

// File: tb/wait_clk_ctrl_bench.sv
`timescale 1ns/1ps
module wait_clk_ctrl_bench;
  localparam int NI = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wait_strobe = 1'b0, stop_strobe = 1'b0, brk_req = 1'b0;
  logic          wdog_off_cfg = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic          cpu_clk_en, per_clk_en, imask_clr, stack_go, brk_wait_flag, wdog_run;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  wait_clk_ctrl #(.N_IRQ(NI)) u_wait_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .wait_strobe(wait_strobe), .stop_strobe(stop_strobe),
    .irq_req(irq_req), .irq_en(irq_en), .brk_req(brk_req), .wdog_off_cfg(wdog_off_cfg),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .imask_clr(imask_clr), .stack_go(stack_go),
    .brk_wait_flag(brk_wait_flag), .wdog_run(wdog_run)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    // R10 reset values
    chk("R10 clk_en", cpu_clk_en, 1'b1);
    chk("R10 flag", brk_wait_flag, 1'b0);
    chk("R10 imask", imask_clr, 1'b0);
    chk("R10 stack", stack_go, 1'b0);
    step(); step();
    rst_n = 1'b1;
    step();

    // R11 interrupt and break while running, no strobe
    irq_req = 4'h1; irq_en = 4'h1; brk_req = 1'b1;
    step();
    irq_req = '0; irq_en = '0; brk_req = 1'b0;
    chk("R11 stack", stack_go, 1'b0);
    chk("R11 flag", brk_wait_flag, 1'b0);
    chk("R11 clk_en", cpu_clk_en, 1'b1);

    // exhaustive sweep of request/enable combinations
    for (int r = 0; r < 16; r++) begin
      for (int e = 0; e < 16; e++) begin
        logic hit;
        hit = |(4'(r) & 4'(e));
        wait_strobe = 1'b1;
        step();
        wait_strobe = 1'b0;
        chk("R1 enter", cpu_clk_en, 1'b0);
        chk("R1 per", per_clk_en, 1'b1);
        chk("R2 mask", imask_clr, 1'b1);
        irq_req = 4'(r); irq_en = 4'(e);
        step();
        irq_req = '0; irq_en = '0;
        chk(hit ? "R3 wake" : "R4 no wake", cpu_clk_en, hit);
        chk(hit ? "R3 stack" : "R4 stack", stack_go, hit);
        chk("R2 single", imask_clr, 1'b0);
        if (hit) begin
          step();
          chk("R3 pulse", stack_go, 1'b0);
        end else begin
          brk_req = 1'b1;
          step();
          brk_req = 1'b0;
          chk("R5 wake", cpu_clk_en, 1'b1);
          chk("R5 flag", brk_wait_flag, 1'b1);
          chk("R5 stack", stack_go, 1'b0);
          flag_wr = 1'b1; flag_wdata = 1'b0;
          step();
          flag_wr = 1'b0;
          chk("R7 clear", brk_wait_flag, 1'b0);
        end
      end
    end

    // R6 watchdog in both states
    wdog_off_cfg = 1'b0;
    #1 chk("R6 run on", wdog_run, 1'b1);
    wait_strobe = 1'b1;
    step();
    wait_strobe = 1'b0;
    chk("R6 idle on", wdog_run, 1'b1);
    wdog_off_cfg = 1'b1;
    #1 chk("R6 idle off", wdog_run, 1'b0);
    wdog_off_cfg = 1'b0;

    // R9 break and interrupt together, plus R7 set wins over clear
    irq_req = 4'h8; irq_en = 4'h8; brk_req = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0;
    step();
    irq_req = '0; irq_en = '0; brk_req = 1'b0; flag_wr = 1'b0;
    chk("R9 clk_en", cpu_clk_en, 1'b1);
    chk("R9 flag", brk_wait_flag, 1'b1);
    chk("R9 stack", stack_go, 1'b0);
    // R7 write of 1 keeps flag
    flag_wr = 1'b1; flag_wdata = 1'b1;
    step();
    chk("R7 write one", brk_wait_flag, 1'b1);
    flag_wdata = 1'b0;
    step();
    flag_wr = 1'b0;
    chk("R7 write zero", brk_wait_flag, 1'b0);

    // R8 wake in the same cycle as the strobe
    wait_strobe = 1'b1; irq_req = 4'h2; irq_en = 4'h2;
    step();
    wait_strobe = 1'b0; irq_req = '0; irq_en = '0;
    chk("R8 irq clk_en", cpu_clk_en, 1'b1);
    chk("R8 irq stack", stack_go, 1'b1);
    chk("R8 irq mask", imask_clr, 1'b1);
    wait_strobe = 1'b1; brk_req = 1'b1;
    step();
    wait_strobe = 1'b0; brk_req = 1'b0;
    chk("R8 brk clk_en", cpu_clk_en, 1'b1);
    chk("R8 brk flag", brk_wait_flag, 1'b1);
    chk("R8 brk stack", stack_go, 1'b0);

    // R2 stop strobe pulses mask clear but keeps CPU clock
    stop_strobe = 1'b1;
    step();
    stop_strobe = 1'b0;
    chk("R2 stop mask", imask_clr, 1'b1);
    chk("R2 stop clk", cpu_clk_en, 1'b1);

    // R10 reset during wait
    wait_strobe = 1'b1;
    step();
    wait_strobe = 1'b0;
    chk("R1 before reset", cpu_clk_en, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R10 async clk_en", cpu_clk_en, 1'b1);
    chk("R10 async flag", brk_wait_flag, 1'b0);
    step();
    rst_n = 1'b1;
    step();
    chk("R10 after", cpu_clk_en, 1'b1);
    chk("R10 stack after", stack_go, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule